// File: doc/BRIEF.md
# Refresh Row Counter with Selectable Terminal

This block keeps the row address used by a multi-bank DRAM controller during refresh. A 9-bit register holds the row to refresh next. It moves forward by one for every completed refresh cycle and returns to zero after the programmed terminal row. Three terminal rows are available: 127, 255 and 511. A set-up strobe picks one of them from a two-bit select field. When the row equals the terminal, an active-low end-of-count flag is driven. On a board, the flag and the clear input can share one open-drain wire.

An external active-low clear returns the row to zero and wins over an advance in the same cycle. A burst helper lets the controller refresh rows back to back without help. A start pulse raises a busy signal. While busy is high, the row advances once per clock. Busy drops when the terminal row is reached, and the row then holds at the terminal.

Top module: `refresh_row_counter`

## Requirements
- R1: A synchronous active-high reset gives row 0, terminal 127 and burst idle. The state is visible on the outputs in the cycle after reset: row_addr = 0, flag_out_n = 1, burst_busy = 0.
- R2: When burst_busy is low and refresh_done is high at a clock edge, row_addr becomes its previous value plus one, unless the row is at the terminal.
- R3: When refresh_done is seen while the row equals the terminal and burst_busy is low, row_addr wraps to 0.
- R4: flag_out_n is 0 exactly when row_addr equals the selected terminal, and 1 otherwise.
- R5: clear_in_n low at a clock edge makes row_addr 0 in the next cycle. This holds even when an advance (refresh_done or burst) is requested in the same cycle.
- R6: A setup_stb edge loads the terminal from sel. The encoding is 2'b00 for 127, 2'b01 for 255, and 2'b10 or 2'b11 for 511. Without setup_stb the terminal holds.
- R7: burst_start while idle sets burst_busy in the next cycle. While burst_busy is high and the row is below the terminal, row_addr advances by one every clock, and refresh_done has no extra effect.
- R8: While burst_busy is high and row_addr equals the terminal, busy clears at the next edge and the row holds at the terminal. burst_start while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| refresh_done | input | 1 | One-cycle strobe, one refresh cycle completed |
| clear_in_n | input | 1 | Active-low external row clear |
| setup_stb | input | 1 | Loads the terminal select |
| sel | input | 2 | Terminal select: 00=127, 01=255, 1x=511 |
| burst_start | input | 1 | Starts an automatic burst of refreshes |
| row_addr | output | 9 | Current refresh row |
| flag_out_n | output | 1 | Active-low end-of-count flag |
| burst_busy | output | 1 | Burst in progress |

## Verification
An external clear and a row advance can fall in the same cycle. The advance may come from a refresh_done strobe or from a running burst. The bench drives clear_in_n low together with refresh_done, and again in the middle of a burst. In both cases it expects row 0 on the next sample, and it expects the burst to keep running from zero up to the terminal.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
    localparam int ROW_W = 9;
    localparam int SEL_W = 2;

    typedef logic [ROW_W-1:0] row_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [SEL_W-1:0] {
        EOC_QUARTER = 2'b00,
        EOC_HALF    = 2'b01,
        EOC_FULL    = 2'b10
    } eoc_sel_e;

    typedef struct packed {
        logic clear;
        logic step;
    } cnt_ctl_t;

    function automatic row_t eoc_limit(input sel_t sel);
        row_t lim;
        case (sel)
            EOC_QUARTER: lim = row_t'((1 << (ROW_W - 2)) - 1);
            EOC_HALF:    lim = row_t'((1 << (ROW_W - 1)) - 1);
            default:     lim = row_t'((1 << ROW_W) - 1);
        endcase
        return lim;
    endfunction
endpackage

// File: rtl/rrc_limit_reg.sv
module rrc_limit_reg
    import rrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic setup_stb,
    input  sel_t sel,
    output row_t limit_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= eoc_limit(EOC_QUARTER);
        end else if (setup_stb) begin
            limit_q <= eoc_limit(sel);
        end
    end
endmodule

// File: rtl/rrc_row_counter.sv
module rrc_row_counter
    import rrc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_ctl_t ctl,
    input  row_t     limit,
    output row_t     row_q,
    output logic     at_end
);
    row_t row_next;

    always_comb begin
        at_end = (row_q == limit);
        if (ctl.clear) begin
            row_next = '0;
        end else if (ctl.step) begin
            row_next = at_end ? '0 : row_q + row_t'(1);
        end else begin
            row_next = row_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else begin
            row_q <= row_next;
        end
    end
endmodule

// File: rtl/rrc_burst_seq.sv
module rrc_burst_seq (
    input  logic clk,
    input  logic rst,
    input  logic burst_start,
    input  logic at_end,
    output logic busy_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (at_end) begin
                busy_q <= 1'b0;
            end
        end else if (burst_start) begin
            busy_q <= 1'b1;
        end
    end
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter
    import rrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             refresh_done,
    input  logic             clear_in_n,
    input  logic             setup_stb,
    input  logic [SEL_W-1:0] sel,
    input  logic             burst_start,
    output logic [ROW_W-1:0] row_addr,
    output logic             flag_out_n,
    output logic             burst_busy
);
    row_t     limit_q;
    row_t     row_q;
    logic     at_end;
    logic     busy_q;
    cnt_ctl_t ctl;

    rrc_limit_reg u_limit (
        .clk       (clk),
        .rst       (rst),
        .setup_stb (setup_stb),
        .sel       (sel),
        .limit_q   (limit_q)
    );

    // A running burst owns the advance; it stops at the terminal instead of wrapping.
    always_comb begin
        ctl.clear = ~clear_in_n;
        ctl.step  = busy_q ? ~at_end : refresh_done;
    end

    rrc_row_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .limit  (limit_q),
        .row_q  (row_q),
        .at_end (at_end)
    );

    rrc_burst_seq u_burst (
        .clk         (clk),
        .rst         (rst),
        .burst_start (burst_start),
        .at_end      (at_end),
        .busy_q      (busy_q)
    );

    assign row_addr   = row_q;
    assign flag_out_n = ~at_end;
    assign burst_busy = busy_q;
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker
    import rrc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic refresh_done,
    input logic clear_in_n,
    input logic setup_stb,
    input sel_t sel,
    input logic burst_start,
    input row_t row_addr,
    input logic flag_out_n,
    input logic burst_busy,
    input row_t limit
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (row_addr == '0 && !burst_busy && flag_out_n && limit == eoc_limit(EOC_QUARTER))); // R1

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (clear_in_n && !burst_busy && refresh_done && row_addr != limit)
        |=> row_addr == $past(row_addr) + row_t'(1)); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clear_in_n && !burst_busy && refresh_done && row_addr == limit) |=> row_addr == '0); // R3

    AST_FLAG_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        (burst_busy && row_addr == limit && clear_in_n && !setup_stb) |=> !flag_out_n); // R4

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        !clear_in_n |=> row_addr == '0); // R5

    AST_LIMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        setup_stb |=> limit == eoc_limit($past(sel))); // R6

    AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !setup_stb |=> $stable(limit)); // R6

    AST_BURST_START: assert property (@(posedge clk) disable iff (rst)
        (!burst_busy && burst_start) |=> burst_busy); // R7

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (burst_busy && clear_in_n && row_addr != limit)
        |=> row_addr == $past(row_addr) + row_t'(1)); // R7

    AST_BURST_STOP: assert property (@(posedge clk) disable iff (rst)
        (burst_busy && row_addr == limit) |=> !burst_busy); // R8

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (burst_busy && row_addr == limit && clear_in_n) |=> $stable(row_addr)); // R8
endmodule

bind refresh_row_counter rrc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .refresh_done (refresh_done),
    .clear_in_n   (clear_in_n),
    .setup_stb    (setup_stb),
    .sel          (sel),
    .burst_start  (burst_start),
    .row_addr     (row_addr),
    .flag_out_n   (flag_out_n),
    .burst_busy   (burst_busy),
    .limit        (limit_q)
);

// File: tb/sim_refresh_row_counter.sv
`timescale 1ns/1ps
module sim_refresh_row_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       refresh_done = 1'b0;
    logic       clear_in_n = 1'b1;
    logic       setup_stb = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       burst_start = 1'b0;
    logic [8:0] row_addr;
    logic       flag_out_n;
    logic       burst_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    refresh_row_counter u0 (
        .clk(clk), .rst(rst), .refresh_done(refresh_done), .clear_in_n(clear_in_n),
        .setup_stb(setup_stb), .sel(sel), .burst_start(burst_start),
        .row_addr(row_addr), .flag_out_n(flag_out_n), .burst_busy(burst_busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic refresh_once();
        refresh_done = 1'b1;
        @(negedge clk);
        refresh_done = 1'b0;
    endtask

    task automatic set_limit(input logic [1:0] s);
        sel = s; setup_stb = 1'b1;
        @(negedge clk);
        setup_stb = 1'b0;
    endtask

    task automatic clear_row();
        clear_in_n = 1'b0;
        @(negedge clk);
        clear_in_n = 1'b1;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1", "row after reset", row_addr, 0);
        chk("R1", "flag after reset", flag_out_n, 1);
        chk("R1", "busy after reset", burst_busy, 0);
    endtask

    task automatic test_step();
        for (int i = 0; i < 5; i++) refresh_once();
        chk("R2", "row after 5 refreshes", row_addr, 5);
        @(negedge clk);
        chk("R2", "row holds with no strobe", row_addr, 5);
    endtask

    task automatic test_wrap_default();
        while (row_addr != 9'd126) refresh_once();
        chk("R4", "flag below terminal", flag_out_n, 1);
        refresh_once();
        chk("R4", "row at default terminal", row_addr, 127);
        chk("R4", "flag at terminal 127", flag_out_n, 0);
        refresh_once();
        chk("R3", "wrap after 127", row_addr, 0);
        chk("R4", "flag after wrap", flag_out_n, 1);
    endtask

    task automatic test_limits();
        set_limit(2'b01);
        while (row_addr != 9'd127) refresh_once();
        chk("R6", "flag at 127 with limit 255", flag_out_n, 1);
        refresh_once();
        chk("R6", "no wrap at 127 with limit 255", row_addr, 128);
        while (row_addr != 9'd255) refresh_once();
        chk("R6", "flag at 255", flag_out_n, 0);
        refresh_once();
        chk("R3", "wrap after 255", row_addr, 0);
        set_limit(2'b11);
        while (row_addr != 9'd511) refresh_once();
        chk("R6", "flag at 511 with sel 11", flag_out_n, 0);
        refresh_once();
        chk("R3", "wrap after 511", row_addr, 0);
        set_limit(2'b00);
    endtask

    task automatic test_clear_priority();
        for (int i = 0; i < 9; i++) refresh_once();
        chk("R5", "row before clear", row_addr, 9);
        clear_in_n = 1'b0; refresh_done = 1'b1;
        @(negedge clk);
        clear_in_n = 1'b1; refresh_done = 1'b0;
        chk("R5", "clear beats refresh", row_addr, 0);
    endtask

    task automatic test_burst();
        int n;
        n = 0;
        clear_row();
        burst_start = 1'b1;
        @(negedge clk);
        burst_start = 1'b0;
        chk("R7", "busy after start", burst_busy, 1);
        chk("R7", "row at burst start", row_addr, 0);
        refresh_done = 1'b1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        refresh_done = 1'b0;
        chk("R7", "one row per clock, strobe absorbed", row_addr, 3);
        burst_start = 1'b1;
        @(negedge clk);
        burst_start = 1'b0;
        chk("R8", "start while busy no effect", row_addr, 4);
        clear_in_n = 1'b0;
        @(negedge clk);
        clear_in_n = 1'b1;
        chk("R5", "clear during burst", row_addr, 0);
        chk("R5", "burst continues after clear", burst_busy, 1);
        while (burst_busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R8", "cycles to stop", n, 128);
        chk("R8", "row holds at terminal", row_addr, 127);
        chk("R8", "flag low at stop", flag_out_n, 0);
        @(negedge clk);
        chk("R8", "row still held", row_addr, 127);
        refresh_once();
        chk("R3", "wrap after burst", row_addr, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_step();
        test_wrap_default();
        test_limits();
        test_clear_priority();
        test_burst();
        test_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule